// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device side of a four-wire serial link (mode 0: data sampled on the rising clock edge and changed on the falling edge) for a paged flash model. While chip select is low it collects a 32-bit command frame, most significant bit first. The frame holds a 4-bit opcode, a 4-bit device ID, a 12-bit page field and a 12-bit byte field. The frame is acted on only when the device ID equals the four strap inputs, so up to sixteen devices can share one bus.

After a valid frame the block streams bytes. Write commands put bytes into one of two 1024-byte buffers. Read commands bring bytes out of a buffer, out of a flash page, or out of the status byte. The byte address advances automatically and wraps.

Transfer, compare and erase commands are not executed here. When chip select returns high, the block hands them to an operation sequencer as a one-cycle strobe.

The serial pins are oversampled by the system clock, which must run at least four times the serial clock. The buffers and the page array are outside the block and are reached through a simple port. Read data on that port is combinational.

Top module: `sflash_cmd_frontend`

## Requirements
- R1: Frame bits are taken on rising serial-clock edges, MSB first, while chip select is low: bits 31:28 opcode, 27:24 device ID, 23:12 page field, 11:0 byte field.
- R2: Opcode decode: 1110/1111 buffer 1/2 read, 0110/0111 buffer 1/2 write, 0001 direct page read, 0000 status read, and 1010, 1011, 0010, 0011, 1100, 1101, 0100, 0101, 1001 are deferred commands; memTarget is 0 for buffer 1, 1 for buffer 2 and 2 for a page.
- R3: For buffer and page reads, soOe first rises after the 35th falling serial-clock edge (low when sampled before rise 35), and the first byte, MSB first, is valid at rises 36 to 43.
- R4: For buffer writes, SI bits from the 33rd rising edge on form bytes MSB first, and each completed byte gives exactly one memWe pulse; memWe and memRe never coincide, and memWe never targets a page.
- R5: The byte address starts at the byte field modulo 1024, increments after each byte and wraps from 1023 to 0; the page is the page field modulo 512.
- R6: A status read shifts out statusIn repeatedly, one byte after another, with the same timing as R3.
- R7: A deferred command with a matching ID raises cmdValid for one cycle after chip select rises, with cmdOp, cmdPage and cmdByte set from the frame.
- R8: If chip select rises before 32 frame bits have arrived, the frame is dropped: no cmdValid, no memWe and no output drive.
- R9: soOe is low while chip select is high, when the ID does not match, and for non-read opcodes; a mismatched frame also causes no memWe and no cmdValid.
- R10: After reset, soOe, memWe, memRe and cmdValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Active-low reset |
| spiCsN | input | 1 | Chip select, active low |
| spiSck | input | 1 | Serial clock |
| spiMosi | input | 1 | Serial data in |
| soData | output | 1 | Serial data out value |
| soOe | output | 1 | Serial data out enable (tri-state control) |
| idStrap | input | 4 | Device ID strap pins |
| statusIn | input | 8 | Status byte to return on a status read |
| memTarget | output | 2 | 0 buffer 1, 1 buffer 2, 2 flash page |
| memPage | output | PAGE_W | Page number for page reads |
| memAddr | output | BYTE_W | Byte address |
| memRe | output | 1 | Read strobe (data captured the same cycle) |
| memWe | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, combinational from the address |
| cmdValid | output | 1 | One-cycle strobe for a deferred command |
| cmdOp | output | 4 | Opcode of the deferred command |
| cmdPage | output | PAGE_W | Page of the deferred command |
| cmdByte | output | BYTE_W | Byte field of the deferred command |

## Verification
The assertions cover the properties that hold on every cycle. They check that the output enable is released once chip select has been high for a few cycles, that writes and reads on the memory port never coincide, that writes never target a page, and that cmdValid lasts one cycle and carries only a deferred opcode.

Other behaviours can only be shown by scenarios that follow a whole frame to its end. These include the exact edge on which read data starts, wrapping at the end of a buffer, the modulo reduction of page numbers, repeated status bytes, and frames dropped because of an ID mismatch or an early chip-select rise.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int OP_W    = 4;
  localparam int ID_W    = 4;
  localparam int FIELD_W = 12;
  localparam int HDR_W   = OP_W + ID_W + 2 * FIELD_W;
  localparam int ID_LSB  = 2 * FIELD_W;
  localparam int OP_LSB  = ID_LSB + ID_W;

  typedef enum logic [1:0] {
    TGT_BUF1 = 2'd0,
    TGT_BUF2 = 2'd1,
    TGT_PAGE = 2'd2
  } tgt_e;

  typedef struct packed {
    logic hdrShift;
    logic hdrLatch;
    logic wrShift;
    logic wrCommit;
    logic rdLoad;
    logic rdShift;
    logic fetch;
  } strobes_t;

  function automatic logic isReadOp(input logic [OP_W-1:0] op);
    return op inside {4'b1110, 4'b1111, 4'b0001, 4'b0000};
  endfunction

  function automatic logic isWriteOp(input logic [OP_W-1:0] op);
    return op inside {4'b0110, 4'b0111};
  endfunction

  function automatic logic isDeferredOp(input logic [OP_W-1:0] op);
    return op inside {4'b1010, 4'b1011, 4'b0010, 4'b0011, 4'b1100,
                      4'b1101, 4'b0100, 4'b0101, 4'b1001};
  endfunction
endpackage

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            sckIn,
  input  logic            csNIn,
  input  logic            siIn,
  input  logic [OP_W-1:0] opcode,
  input  logic            idOk,
  output logic            siBit,
  output strobes_t        stb,
  output logic            cmdValid,
  output logic            soOe
);
  localparam logic [5:0] HDR_CNT = 6'(HDR_W);
  localparam logic [2:0] FIRST_OUT = 3'd3;

  logic [1:0] sckS, csS, siS;
  logic       sckPrev, csPrev;
  logic [5:0] riseCnt;
  logic [2:0] dataCnt;
  logic       started, fetchPend;
  logic       sckRise, sckFall, csRise, headerDone, csHigh;
  logic       rdOk, wrOk;

  assign csHigh     = csS[1];
  assign sckRise    = sckS[1] & ~sckPrev & ~csHigh;
  assign sckFall    = ~sckS[1] & sckPrev & ~csHigh;
  assign csRise     = csHigh & ~csPrev;
  assign headerDone = (riseCnt == HDR_CNT);
  assign siBit      = siS[1];
  assign rdOk       = headerDone && idOk && isReadOp(opcode);
  assign wrOk       = headerDone && idOk && isWriteOp(opcode);

  always_comb begin
    stb          = '0;
    stb.hdrShift = sckRise && !headerDone;
    stb.hdrLatch = sckRise && (riseCnt == HDR_CNT - 6'd1);
    stb.wrShift  = sckRise && wrOk;
    stb.wrCommit = stb.wrShift && (dataCnt == 3'd7);
    stb.rdLoad   = sckFall && rdOk && (dataCnt == FIRST_OUT);
    stb.rdShift  = sckFall && rdOk && started && !stb.rdLoad;
    stb.fetch    = fetchPend && rdOk && !csHigh;
  end

  assign cmdValid = csRise && headerDone && idOk && isDeferredOp(opcode);
  assign soOe     = started && !csHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS      <= '0;
      csS       <= 2'b11;
      siS       <= '0;
      sckPrev   <= 1'b0;
      csPrev    <= 1'b1;
      riseCnt   <= '0;
      dataCnt   <= '0;
      started   <= 1'b0;
      fetchPend <= 1'b0;
    end else begin
      sckS    <= {sckS[0], sckIn};
      csS     <= {csS[0], csNIn};
      siS     <= {siS[0], siIn};
      sckPrev <= sckS[1];
      csPrev  <= csS[1];
      if (csHigh) begin
        riseCnt   <= '0;
        dataCnt   <= '0;
        started   <= 1'b0;
        fetchPend <= 1'b0;
      end else begin
        if (sckRise) begin
          if (!headerDone) riseCnt <= riseCnt + 6'd1;
          else             dataCnt <= dataCnt + 3'd1;
        end
        if (stb.rdLoad) started <= 1'b1;
        fetchPend <= stb.hdrLatch || stb.rdLoad;
      end
    end
  end
endmodule

// File: rtl/sfe_dpath.sv
module sfe_dpath
  import sfe_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int BYTE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              siBit,
  input  logic [ID_W-1:0]   idStrap,
  input  logic [7:0]        statusIn,
  input  logic [7:0]        memRdata,
  output logic [OP_W-1:0]   opcode,
  output logic              idOk,
  output logic [1:0]        memTarget,
  output logic [PAGE_W-1:0] memPage,
  output logic [BYTE_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [7:0]        memWdata,
  output logic              soData
);
  localparam logic [OP_W-1:0] OP_STATUS = 4'b0000;
  localparam logic [OP_W-1:0] OP_PGREAD = 4'b0001;

  logic [HDR_W-1:0]  hdr, nextHdr;
  logic [BYTE_W-1:0] addr;
  logic [PAGE_W-1:0] page;
  logic [6:0]        wrSh;
  logic [7:0]        outSh, nextByte;
  tgt_e              tgt;

  assign nextHdr = {hdr[HDR_W-2:0], siBit};
  assign opcode  = hdr[OP_LSB +: OP_W];
  assign idOk    = (hdr[ID_LSB +: ID_W] == idStrap);

  always_comb begin
    if (opcode == OP_PGREAD) tgt = TGT_PAGE;
    else if (opcode[0])      tgt = TGT_BUF2;
    else                     tgt = TGT_BUF1;
  end

  assign memTarget = tgt;
  assign memPage   = page;
  assign memAddr   = addr;
  assign memWe     = stb.wrCommit;
  assign memWdata  = {wrSh, siBit};
  assign memRe     = stb.fetch && (opcode != OP_STATUS);
  assign soData    = outSh[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdr      <= '0;
      addr     <= '0;
      page     <= '0;
      wrSh     <= '0;
      outSh    <= '0;
      nextByte <= '0;
    end else begin
      if (stb.hdrShift) hdr <= nextHdr;
      if (stb.hdrLatch) begin
        addr <= nextHdr[0 +: BYTE_W];
        page <= nextHdr[FIELD_W +: PAGE_W];
      end
      if (stb.wrShift) wrSh <= {wrSh[5:0], siBit};
      if (stb.wrCommit || stb.rdLoad) addr <= addr + 1'b1;
      if (stb.fetch) nextByte <= (opcode == OP_STATUS) ? statusIn : memRdata;
      if (stb.rdLoad)       outSh <= nextByte;
      else if (stb.rdShift) outSh <= {outSh[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/sflash_cmd_frontend.sv
module sflash_cmd_frontend
  import sfe_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int BYTE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSck,
  input  logic              spiMosi,
  output logic              soData,
  output logic              soOe,
  input  logic [3:0]        idStrap,
  input  logic [7:0]        statusIn,
  output logic [1:0]        memTarget,
  output logic [PAGE_W-1:0] memPage,
  output logic [BYTE_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              cmdValid,
  output logic [3:0]        cmdOp,
  output logic [PAGE_W-1:0] cmdPage,
  output logic [BYTE_W-1:0] cmdByte
);
  strobes_t        stb;
  logic            siBit, idOk;
  logic [OP_W-1:0] opcode;

  sfe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(spiSck), .csNIn(spiCsN), .siIn(spiMosi),
    .opcode(opcode), .idOk(idOk), .siBit(siBit), .stb(stb),
    .cmdValid(cmdValid), .soOe(soOe)
  );

  sfe_dpath #(.PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .siBit(siBit), .idStrap(idStrap),
    .statusIn(statusIn), .memRdata(memRdata), .opcode(opcode), .idOk(idOk),
    .memTarget(memTarget), .memPage(memPage), .memAddr(memAddr),
    .memRe(memRe), .memWe(memWe), .memWdata(memWdata), .soData(soData)
  );

  assign cmdOp   = opcode;
  assign cmdPage = memPage;
  assign cmdByte = memAddr;
endmodule

// File: rtl/sflash_cmd_frontend_chk.sv
module sflash_cmd_frontend_chk
  import sfe_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       spiCsN,
  input logic       soOe,
  input logic       memWe,
  input logic       memRe,
  input logic [1:0] memTarget,
  input logic       cmdValid,
  input logic [3:0] cmdOp
);
  AST_OE_QUIET_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (spiCsN && $past(spiCsN) && $past(spiCsN, 2) && $past(spiCsN, 3)) |-> !soOe); // R9
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R4
  AST_WE_NOT_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memTarget != 2'd2)); // R4
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid); // R7
  AST_CMD_DEFERRED_OP: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> isDeferredOp(cmdOp)); // R7
endmodule

bind sflash_cmd_frontend sflash_cmd_frontend_chk u_chk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .soOe(soOe), .memWe(memWe),
  .memRe(memRe), .memTarget(memTarget), .cmdValid(cmdValid), .cmdOp(cmdOp)
);

// File: tb/sflash_cmd_frontend_tb.sv
module sflash_cmd_frontend_tb;
  localparam int PAGE_W = 9;
  localparam int BYTE_W = 10;
  localparam int HALF   = 8;
  localparam logic [3:0] MY_ID = 4'hA;

  logic clk = 1'b0, rstN = 1'b0, spiCsN = 1'b1, spiSck = 1'b0, spiMosi = 1'b0;
  logic soData, soOe, memRe, memWe, cmdValid;
  logic [3:0] idStrap = MY_ID, cmdOp;
  logic [7:0] statusIn = 8'hA7, memWdata, memRdata;
  logic [1:0] memTarget;
  logic [PAGE_W-1:0] memPage, cmdPage;
  logic [BYTE_W-1:0] memAddr, cmdByte;

  int checks = 0, fails = 0, cmdCount = 0, weCount = 0;
  logic [3:0] lastOp;
  logic [PAGE_W-1:0] lastPage;
  logic [BYTE_W-1:0] lastByte;
  logic [7:0] bufA [1024];
  logic [7:0] bufB [1024];
  logic [7:0] txB [16];
  logic [7:0] rxB [16];
  logic oeBefore, oeAny;

  always #10 clk = ~clk;

  sflash_cmd_frontend #(.PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_dut (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi),
    .soData(soData), .soOe(soOe), .idStrap(idStrap), .statusIn(statusIn),
    .memTarget(memTarget), .memPage(memPage), .memAddr(memAddr), .memRe(memRe),
    .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdPage(cmdPage), .cmdByte(cmdByte)
  );

  function automatic logic [7:0] pageByte(input int p, input int b);
    return 8'((p * 13 + b * 7 + 60) & 255);
  endfunction

  function automatic logic [31:0] mkHdr(input logic [3:0] op, input logic [3:0] id,
                                        input logic [11:0] pg, input logic [11:0] by);
    return {op, id, pg, by};
  endfunction

  always_comb begin
    case (memTarget)
      2'd0:    memRdata = bufA[memAddr];
      2'd1:    memRdata = bufB[memAddr];
      default: memRdata = pageByte(int'(memPage), int'(memAddr));
    endcase
  end

  always @(posedge clk) begin
    if (memWe) begin
      if (memTarget == 2'd0) bufA[memAddr] <= memWdata;
      else if (memTarget == 2'd1) bufB[memAddr] <= memWdata;
    end
  end

  always @(negedge clk) begin
    if (cmdValid) begin
      cmdCount++;
      lastOp = cmdOp; lastPage = cmdPage; lastByte = cmdByte;
    end
    if (memWe) weCount++;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nBytes data bytes; cutAt > 0 stops after that many rising edges
  task automatic xfer(input logic [31:0] hdr, input int nBytes, input int cutAt);
    int total;
    total = (cutAt > 0) ? cutAt : 35 + 8 * nBytes;
    oeBefore = 1'b0; oeAny = 1'b0;
    for (int i = 0; i < 16; i++) rxB[i] = 8'h00;
    waitClk(2);
    spiCsN = 1'b0;
    waitClk(HALF);
    for (int r = 1; r <= total; r++) begin
      if (r <= 32) spiMosi = hdr[32 - r];
      else if ((r - 33) / 8 < 16) spiMosi = txB[(r - 33) / 8][7 - ((r - 33) % 8)];
      waitClk(HALF);
      if (soOe) oeAny = 1'b1;
      if (r == 35) oeBefore = soOe;
      if (r >= 36 && (r - 36) / 8 < 16) rxB[(r - 36) / 8][7 - ((r - 36) % 8)] = soData;
      spiSck = 1'b1;
      waitClk(HALF);
      spiSck = 1'b0;
    end
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(10);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int c0, w0;
    logic [9:0] a;
    int n;
    logic sel;
    logic [7:0] d [4];
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) begin bufA[i] = 8'h00; bufB[i] = 8'h00; end
    waitClk(5);
    // R10 reset state
    check(!soOe && !memWe && !memRe && !cmdValid, "R10 reset outputs", {soOe, memWe, memRe, cmdValid}, 0);
    rstN = 1'b1;
    waitClk(5);

    // R4 R5 write buffer 1 across the wrap point
    txB[0] = 8'h11; txB[1] = 8'h22; txB[2] = 8'h33;
    w0 = weCount;
    xfer(mkHdr(4'b0110, MY_ID, 12'h000, 12'hBFE), 3, 0);
    check(weCount - w0 == 3, "R4 one write per byte", weCount - w0, 3);
    check(bufA[1022] == 8'h11 && bufA[1023] == 8'h22, "R5 write start modulo", bufA[1023], 8'h22);
    check(bufA[0] == 8'h33, "R5 write wraps to 0", bufA[0], 8'h33);

    // R3 R5 read buffer 1 back across wrap
    xfer(mkHdr(4'b1110, MY_ID, 12'h000, 12'h3FE), 3, 0);
    check(!oeBefore, "R3 no drive before 35th fall", oeBefore, 0);
    check(rxB[0] == 8'h11 && rxB[1] == 8'h22, "R3 read data MSB first", {rxB[0], rxB[1]}, 16'h1122);
    check(rxB[2] == 8'h33, "R5 read wraps", rxB[2], 8'h33);

    // R1 R2 buffer 2 write/read
    txB[0] = 8'hC3; txB[1] = 8'h5A;
    xfer(mkHdr(4'b0111, MY_ID, 12'h123, 12'h010), 2, 0);
    check(bufB[16] == 8'hC3 && bufB[17] == 8'h5A && bufA[16] == 8'h00, "R2 buffer 2 selected", bufB[16], 8'hC3);
    xfer(mkHdr(4'b1111, MY_ID, 12'h000, 12'h010), 2, 0);
    check(rxB[0] == 8'hC3 && rxB[1] == 8'h5A, "R1 buffer 2 read", {rxB[0], rxB[1]}, 16'hC35A);

    // R5 direct page read, page modulo 512, byte wrap
    xfer(mkHdr(4'b0001, MY_ID, 12'hFFF, 12'h3FF), 2, 0);
    check(rxB[0] == pageByte(511, 1023), "R5 page read modulo", rxB[0], pageByte(511, 1023));
    check(rxB[1] == pageByte(511, 0), "R5 page read wrap", rxB[1], pageByte(511, 0));

    // R6 status read repeats
    xfer(mkHdr(4'b0000, MY_ID, 12'h000, 12'h000), 3, 0);
    check(rxB[0] == 8'hA7 && rxB[1] == 8'hA7 && rxB[2] == 8'hA7, "R6 status repeated", rxB[2], 8'hA7);

    // R9 mismatched ID write and read
    txB[0] = 8'hEE;
    w0 = weCount;
    xfer(mkHdr(4'b0110, 4'h3, 12'h000, 12'h000), 1, 0);
    check(weCount == w0 && bufA[0] == 8'h33, "R9 mismatched write ignored", bufA[0], 8'h33);
    xfer(mkHdr(4'b1110, 4'h3, 12'h000, 12'h000), 2, 0);
    check(!oeAny, "R9 mismatched read not driven", oeAny, 0);

    // R7 deferred command handed over at CS rise
    c0 = cmdCount;
    xfer(mkHdr(4'b1011, MY_ID, 12'hA05, 12'h7FF), 0, 0);
    check(cmdCount == c0 + 1, "R7 one cmdValid", cmdCount - c0, 1);
    check(lastOp == 4'b1011 && lastPage == 9'd5 && lastByte == 10'h3FF, "R7 cmd fields",
          {lastOp, 3'b0, lastPage, 2'b0, lastByte}, {4'hB, 3'b0, 9'd5, 2'b0, 10'h3FF});
    check(!oeAny, "R9 non-read not driven", oeAny, 0);

    // R9 deferred with mismatched ID
    c0 = cmdCount;
    xfer(mkHdr(4'b1001, 4'h0, 12'h000, 12'h000), 0, 0);
    check(cmdCount == c0, "R9 mismatched deferred ignored", cmdCount - c0, 0);

    // R8 abort before the frame is complete
    c0 = cmdCount; w0 = weCount;
    xfer(mkHdr(4'b1100, MY_ID, 12'h001, 12'h000), 0, 20);
    check(cmdCount == c0 && weCount == w0 && !oeAny, "R8 short frame dropped", cmdCount - c0, 0);

    // R3 R4 constrained random write/read-back
    for (int it = 0; it < 8; it++) begin
      sel = 1'($urandom % 2);
      a = 10'($urandom);
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < 4; k++) begin d[k] = 8'($urandom); txB[k] = d[k]; end
      xfer(mkHdr({3'b011, sel}, MY_ID, 12'($urandom), {2'($urandom), a}), n, 0);
      xfer(mkHdr({3'b111, sel}, MY_ID, 12'($urandom), {2'($urandom), a}), n, 0);
      for (int k = 0; k < n; k++)
        check(rxB[k] == d[k], "R4 random write/read", rxB[k], d[k]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule